// File: doc/BRIEF.md
# Maskable Interrupt Flag Aggregator

This block collects interrupt events from the functions around a serial slave port and holds them as sticky flags. It keeps two flag groups. The primary group is eight bits wide. The extended group is shown as a 32-bit register, and only its lowest byte is implemented. Each group has its own mask register. An event pulse sets its flag whatever the mask holds. Flags are not cleared by software writes. They clear as a side effect of other activity: a status register read, a frame-info register read, the completion of a DMX read command, or a read of the RX/TX status register. The extended group is cleared either by that RX/TX status read or by per-bit clear pulses that come from the command decoder.

Bit 6 of the primary group is not stored. It is a summary of the extended group and is high whenever an enabled extended flag is pending. The active-low interrupt pin is driven low in two cases: an enabled primary flag in bits 0 to 6 is pending, or the slave front end raises a command-ready request. The pin is forced inactive for one cycle after every completed transaction, and then follows the request again. This produces a fresh high-to-low edge for the host.

Top module: `irq_flag_hub`

## Requirements
- R1: After reset, all flags and both masks read 0 and `irq_n_o` is 1.
- R2: A pulse on a source event input sets its primary flag (source bit k sets flag bit k, for k = 0 to 5) on the next clock edge, regardless of the mask. The flag stays set until it is cleared.
- R3: A status read pulse clears primary flags 1 (stream lost), 3 (link change) and 5 (identify) and leaves all other flags unchanged.
- R4: A DMX-read-done pulse clears primary flags 0 (frame received) and 2 (window changed). A frame-info read pulse clears primary flag 4 (alternate start code).
- R5: When a set event and a clear event reach the same flag in the same cycle, the flag ends set.
- R6: Extended flags occupy bits 7:0 of `ext_flags_o`, and bits 31:8 read 0. `ext_evt_i[k]` sets extended bit k. `ext_clr_i[k]` clears it. An RX/TX status read pulse clears bits 1 (data available) and 2 (clear to send).
- R7: `pri_flags_o[6]` is 1 exactly when some extended flag is set with its extended mask bit also set. This is combinational, with no added cycle.
- R8: `irq_n_o` goes low on the edge after the cycle in which `(pri_flags_o[6:0] & pri_mask_o[6:0]) != 0` or `cmd_rdy_i` is 1. It is high otherwise, so a flag whose mask bit is 0 never pulls the pin low.
- R9: A `txn_end_i` pulse makes `irq_n_o` 1 on the following edge even when a request is active. On the edge after that, the pin follows the request again.
- R10: Primary bit 7 (busy) is set by `busy_evt_i` and cleared by `txn_end_i`. It never drives `irq_n_o`.
- R11: A mask write loads the mask on the next edge. `pri_mask_o[7]` always reads 0, and `ext_mask_o[31:8]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt_i | input | 6 | Set pulses for primary flags 0 to 5 |
| busy_evt_i | input | 1 | Set pulse for the busy flag (bit 7) |
| ext_evt_i | input | EXT_USED | Set pulses for extended flags |
| ext_clr_i | input | EXT_USED | Clear pulses for extended flags, driven by read commands |
| status_rd_i | input | 1 | Status register was read |
| dmx_rd_done_i | input | 1 | DMX read command completed |
| frame_info_rd_i | input | 1 | Alternate start-code frame-info register was read |
| rxtx_status_rd_i | input | 1 | RX/TX status register was read |
| txn_end_i | input | 1 | A serial transaction completed successfully |
| cmd_rdy_i | input | 1 | Front end requests the pin for command-ready |
| pmask_we_i | input | 1 | Primary mask write strobe |
| pmask_wdata_i | input | 7 | Primary mask write data (bits 6:0) |
| emask_we_i | input | 1 | Extended mask write strobe |
| emask_wdata_i | input | EXT_USED | Extended mask write data |
| pri_flags_o | output | 8 | Primary flag register view |
| ext_flags_o | output | EXT_W | Extended flag register view |
| pri_mask_o | output | 8 | Primary mask register view |
| ext_mask_o | output | EXT_W | Extended mask register view |
| irq_n_o | output | 1 | Active-low interrupt pin |

## Verification
Two functions can meet on the same flag in the same cycle: an event that sets a flag, and a read side effect that clears it. The bench drives a stream-lost event together with a status read, and a frame-received event together with a DMX-read-done, on the same edge. It then expects both flags to remain set, and a later clear-only pulse to remove them. A second collision is a transaction end against a pending enabled flag. This is judged by the pin reading high for exactly one cycle and low again on the next.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
   // primary flag bit positions (host decodes these)
   localparam int unsigned P_RX_FRAME  = 0;
   localparam int unsigned P_LOST      = 1;
   localparam int unsigned P_WIN_CHG   = 2;
   localparam int unsigned P_LINK      = 3;
   localparam int unsigned P_ALT_SC    = 4;
   localparam int unsigned P_IDENT     = 5;
   localparam int unsigned P_EXT_SUM   = 6;
   localparam int unsigned P_BUSY      = 7;
   localparam int unsigned PRI_W       = 8;
   localparam int unsigned SRC_W       = 6;
   // extended flag bit positions
   localparam int unsigned X_DATA_AVL  = 1;
   localparam int unsigned X_CLR_SEND  = 2;
endpackage

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flags_o
);
   logic [W-1:0] flags_q;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags_q[i] <= 1'b0;
            else if (set_i[i]) flags_q[i] <= 1'b1;   // set has priority
            else if (clr_i[i]) flags_q[i] <= 1'b0;
         end
      end
   endgenerate

   assign flags_o = flags_q;
endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
   parameter int unsigned W         = 8,
   parameter logic [W-1:0] RST_VAL  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);
   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q <= RST_VAL;
      else if (we_i) mask_q <= wdata_i;
   end

   assign mask_o = mask_q;
endmodule

// File: rtl/irq_pin_ctrl.sv
`timescale 1ns/1ps
module irq_pin_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic txn_end_i,
   output logic irq_n_o
);
   logic irq_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_n_q <= 1'b1;
      else if (txn_end_i) irq_n_q <= 1'b1;   // one-cycle release after a transaction
      else                irq_n_q <= ~req_i;
   end

   assign irq_n_o = irq_n_q;
endmodule

// File: rtl/irq_flag_hub.sv
`timescale 1ns/1ps
module irq_flag_hub #(
   parameter int unsigned EXT_W    = 32,
   parameter int unsigned EXT_USED = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [5:0]          src_evt_i,
   input  logic                busy_evt_i,
   input  logic [EXT_USED-1:0] ext_evt_i,
   input  logic [EXT_USED-1:0] ext_clr_i,
   input  logic                status_rd_i,
   input  logic                dmx_rd_done_i,
   input  logic                frame_info_rd_i,
   input  logic                rxtx_status_rd_i,
   input  logic                txn_end_i,
   input  logic                cmd_rdy_i,
   input  logic                pmask_we_i,
   input  logic [6:0]          pmask_wdata_i,
   input  logic                emask_we_i,
   input  logic [EXT_USED-1:0] emask_wdata_i,
   output logic [7:0]          pri_flags_o,
   output logic [EXT_W-1:0]    ext_flags_o,
   output logic [7:0]          pri_mask_o,
   output logic [EXT_W-1:0]    ext_mask_o,
   output logic                irq_n_o
);
   import irq_hub_pkg::*;

   generate
      if (EXT_USED > EXT_W) begin : g_bad_width
         $error("irq_flag_hub: EXT_USED exceeds EXT_W");
      end
      if (EXT_USED <= X_CLR_SEND) begin : g_bad_used
         $error("irq_flag_hub: EXT_USED too small for RX/TX status bits");
      end
   endgenerate

   // ---------------- primary sources ----------------
   logic [SRC_W-1:0] src_clr;
   logic [SRC_W-1:0] src_q;
   logic             busy_q;

   always_comb begin
      src_clr             = '0;
      src_clr[P_LOST]     = status_rd_i;
      src_clr[P_LINK]     = status_rd_i;
      src_clr[P_IDENT]    = status_rd_i;
      src_clr[P_RX_FRAME] = dmx_rd_done_i;
      src_clr[P_WIN_CHG]  = dmx_rd_done_i;
      src_clr[P_ALT_SC]   = frame_info_rd_i;
   end

   irq_flag_bank #(.W(SRC_W)) u_src_bank (
      .clk(clk), .rst_n(rst_n),
      .set_i(src_evt_i), .clr_i(src_clr), .flags_o(src_q));

   irq_flag_bank #(.W(1)) u_busy_bank (
      .clk(clk), .rst_n(rst_n),
      .set_i(busy_evt_i), .clr_i(txn_end_i), .flags_o(busy_q));

   // ---------------- extended group ----------------
   logic [EXT_USED-1:0] ext_clr_all;
   logic [EXT_USED-1:0] ext_q;
   logic [EXT_USED-1:0] emask_q;
   logic [6:0]          pmask_q;
   logic                ext_sum;

   always_comb begin
      ext_clr_all             = ext_clr_i;
      ext_clr_all[X_DATA_AVL] = ext_clr_i[X_DATA_AVL] | rxtx_status_rd_i;
      ext_clr_all[X_CLR_SEND] = ext_clr_i[X_CLR_SEND] | rxtx_status_rd_i;
   end

   irq_flag_bank #(.W(EXT_USED)) u_ext_bank (
      .clk(clk), .rst_n(rst_n),
      .set_i(ext_evt_i), .clr_i(ext_clr_all), .flags_o(ext_q));

   irq_mask_reg #(.W(EXT_USED)) u_emask (
      .clk(clk), .rst_n(rst_n),
      .we_i(emask_we_i), .wdata_i(emask_wdata_i), .mask_o(emask_q));

   irq_mask_reg #(.W(7)) u_pmask (
      .clk(clk), .rst_n(rst_n),
      .we_i(pmask_we_i), .wdata_i(pmask_wdata_i), .mask_o(pmask_q));

   assign ext_sum = |(ext_q & emask_q);

   generate
      if (EXT_W > EXT_USED) begin : g_pad
         assign ext_flags_o = {{(EXT_W-EXT_USED){1'b0}}, ext_q};
         assign ext_mask_o  = {{(EXT_W-EXT_USED){1'b0}}, emask_q};
      end else begin : g_full
         assign ext_flags_o = ext_q;
         assign ext_mask_o  = emask_q;
      end
   endgenerate

   // ---------------- register views and pin ----------------
   assign pri_flags_o = {busy_q, ext_sum, src_q};
   assign pri_mask_o  = {1'b0, pmask_q};

   logic irq_req;
   assign irq_req = (|({ext_sum, src_q} & pmask_q)) | cmd_rdy_i;

   irq_pin_ctrl u_pin (
      .clk(clk), .rst_n(rst_n),
      .req_i(irq_req), .txn_end_i(txn_end_i), .irq_n_o(irq_n_o));
endmodule

// File: rtl/irq_flag_hub_chk.sv
`timescale 1ns/1ps
module irq_flag_hub_chk #(
   parameter int unsigned EXT_W    = 32,
   parameter int unsigned EXT_USED = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [5:0]          src_evt_i,
   input logic [EXT_USED-1:0] ext_evt_i,
   input logic                status_rd_i,
   input logic                dmx_rd_done_i,
   input logic                rxtx_status_rd_i,
   input logic                txn_end_i,
   input logic                cmd_rdy_i,
   input logic [7:0]          pri_flags_o,
   input logic [EXT_W-1:0]    ext_flags_o,
   input logic [7:0]          pri_mask_o,
   input logic                irq_n_o
);
   AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_evt_i[0] && !pri_flags_o[0]) |=> !pri_flags_o[0]); // R2
   AST_STATUS_CLEARS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd_i && !src_evt_i[1]) |=> !pri_flags_o[1]); // R3
   AST_DMX_CLEARS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (dmx_rd_done_i && !src_evt_i[0]) |=> !pri_flags_o[0]); // R4
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      src_evt_i[1] |=> pri_flags_o[1]); // R5
   AST_RXTX_CLEARS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (rxtx_status_rd_i && !ext_evt_i[1]) |=> !ext_flags_o[1]); // R6
   AST_IDLE_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_rdy_i && ((pri_flags_o[6:0] & pri_mask_o[6:0]) == 7'd0)) |=> irq_n_o); // R8
   AST_TXN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      txn_end_i |=> irq_n_o); // R9
endmodule

bind irq_flag_hub irq_flag_hub_chk #(.EXT_W(EXT_W), .EXT_USED(EXT_USED)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt_i), .ext_evt_i(ext_evt_i),
   .status_rd_i(status_rd_i), .dmx_rd_done_i(dmx_rd_done_i),
   .rxtx_status_rd_i(rxtx_status_rd_i), .txn_end_i(txn_end_i), .cmd_rdy_i(cmd_rdy_i),
   .pri_flags_o(pri_flags_o), .ext_flags_o(ext_flags_o), .pri_mask_o(pri_mask_o),
   .irq_n_o(irq_n_o));

// File: tb/irq_flag_hub_tb_top.sv
`timescale 1ns/1ps
module irq_flag_hub_tb_top;
   localparam int unsigned EXT_W = 32;
   localparam int unsigned EXT_USED = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [5:0] src_evt_i = '0;
   logic busy_evt_i = 1'b0;
   logic [EXT_USED-1:0] ext_evt_i = '0;
   logic [EXT_USED-1:0] ext_clr_i = '0;
   logic status_rd_i = 1'b0, dmx_rd_done_i = 1'b0, frame_info_rd_i = 1'b0;
   logic rxtx_status_rd_i = 1'b0, txn_end_i = 1'b0, cmd_rdy_i = 1'b0;
   logic pmask_we_i = 1'b0;
   logic [6:0] pmask_wdata_i = '0;
   logic emask_we_i = 1'b0;
   logic [EXT_USED-1:0] emask_wdata_i = '0;
   logic [7:0] pri_flags_o, pri_mask_o;
   logic [EXT_W-1:0] ext_flags_o, ext_mask_o;
   logic irq_n_o;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   irq_flag_hub #(.EXT_W(EXT_W), .EXT_USED(EXT_USED)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt_i), .busy_evt_i(busy_evt_i),
      .ext_evt_i(ext_evt_i), .ext_clr_i(ext_clr_i), .status_rd_i(status_rd_i),
      .dmx_rd_done_i(dmx_rd_done_i), .frame_info_rd_i(frame_info_rd_i),
      .rxtx_status_rd_i(rxtx_status_rd_i), .txn_end_i(txn_end_i), .cmd_rdy_i(cmd_rdy_i),
      .pmask_we_i(pmask_we_i), .pmask_wdata_i(pmask_wdata_i),
      .emask_we_i(emask_we_i), .emask_wdata_i(emask_wdata_i),
      .pri_flags_o(pri_flags_o), .ext_flags_o(ext_flags_o),
      .pri_mask_o(pri_mask_o), .ext_mask_o(ext_mask_o), .irq_n_o(irq_n_o));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // inputs change at negedge; the result of one edge is seen at the next negedge
   task automatic step();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", "pri flags", 32'(pri_flags_o), 32'h0);
      chk("R1", "ext flags", ext_flags_o, 32'h0);
      chk("R1", "masks", {8'(pri_mask_o), ext_mask_o[23:0]}, 32'h0);
      chk("R1", "irq pin", 32'(irq_n_o), 32'h1);
   endtask

   task automatic t_set_unmasked();
      src_evt_i = 6'h3F; step(); src_evt_i = '0;
      chk("R2", "all sources set", 32'(pri_flags_o), 32'h3F);
      step();
      chk("R8", "masked flags keep pin high", 32'(irq_n_o), 32'h1);
   endtask

   task automatic t_side_clears();
      status_rd_i = 1'b1; step(); status_rd_i = 1'b0;
      chk("R3", "status read clears 1,3,5", 32'(pri_flags_o), 32'h15);
      dmx_rd_done_i = 1'b1; step(); dmx_rd_done_i = 1'b0;
      chk("R4", "dmx done clears 0,2", 32'(pri_flags_o), 32'h10);
      frame_info_rd_i = 1'b1; step(); frame_info_rd_i = 1'b0;
      chk("R4", "frame info clears 4", 32'(pri_flags_o), 32'h0);
   endtask

   task automatic t_set_wins();
      src_evt_i = 6'h03; status_rd_i = 1'b1; dmx_rd_done_i = 1'b1; step();
      src_evt_i = '0;
      chk("R5", "set beats clear", 32'(pri_flags_o), 32'h03);
      step(); status_rd_i = 1'b0; dmx_rd_done_i = 1'b0;
      chk("R5", "later clear removes", 32'(pri_flags_o), 32'h0);
   endtask

   task automatic t_pin();
      pmask_we_i = 1'b1; pmask_wdata_i = 7'h7F; step(); pmask_we_i = 1'b0;
      chk("R11", "primary mask bit7 reads 0", 32'(pri_mask_o), 32'h7F);
      src_evt_i = 6'h08; step(); src_evt_i = '0;
      chk("R8", "pin not yet low", 32'(irq_n_o), 32'h1);
      step();
      chk("R8", "pin low on pending link flag", 32'(irq_n_o), 32'h0);
      txn_end_i = 1'b1; step(); txn_end_i = 1'b0;
      chk("R9", "released after transaction", 32'(irq_n_o), 32'h1);
      step();
      chk("R9", "reasserted next cycle", 32'(irq_n_o), 32'h0);
      status_rd_i = 1'b1; step(); status_rd_i = 1'b0;
      step();
      chk("R8", "pin high after clear", 32'(irq_n_o), 32'h1);
      cmd_rdy_i = 1'b1; step();
      chk("R8", "command ready pulls low", 32'(irq_n_o), 32'h0);
      cmd_rdy_i = 1'b0; step();
      chk("R8", "command ready dropped", 32'(irq_n_o), 32'h1);
   endtask

   task automatic t_ext();
      ext_evt_i = 8'hFF; step(); ext_evt_i = '0;
      chk("R6", "ext flags low byte only", ext_flags_o, 32'h0000_00FF);
      chk("R7", "summary off with zero mask", 32'(pri_flags_o[6]), 32'h0);
      emask_we_i = 1'b1; emask_wdata_i = 8'h04; step(); emask_we_i = 1'b0;
      chk("R11", "ext mask upper reads 0", ext_mask_o, 32'h0000_0004);
      chk("R7", "summary on", 32'(pri_flags_o[6]), 32'h1);
      rxtx_status_rd_i = 1'b1; step(); rxtx_status_rd_i = 1'b0;
      chk("R6", "rxtx read clears 1,2", ext_flags_o, 32'h0000_00F9);
      chk("R7", "summary off after clear", 32'(pri_flags_o[6]), 32'h0);
      ext_clr_i = 8'h01; step(); ext_clr_i = '0;
      chk("R6", "per-bit clear", ext_flags_o, 32'h0000_00F8);
   endtask

   task automatic t_busy();
      step();
      busy_evt_i = 1'b1; step(); busy_evt_i = 1'b0;
      chk("R10", "busy set", 32'(pri_flags_o), 32'h80);
      step();
      chk("R10", "busy does not drive pin", 32'(irq_n_o), 32'h1);
      txn_end_i = 1'b1; step(); txn_end_i = 1'b0;
      chk("R10", "busy cleared by transaction end", 32'(pri_flags_o), 32'h0);
   endtask

   initial begin
      #(200_000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      step(); step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_set_unmasked();
      t_side_clears();
      t_set_wins();
      t_pin();
      t_ext();
      t_busy();
      step();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule